// File: doc/BRIEF.md
# Virtualization Root/Guest Mode Sequencer

This block tracks whether a processor core is running with virtualization switched off, in host (root) mode, or in guest mode, and sequences every change between them. It takes decoded command strobes (enable, disable, first launch, resume, guest hypercall) and event strobes (external interrupt, page fault). It drives single-cycle requests toward a context store that holds the saved guest and host state. The context store answers each request with a one-cycle done strobe. The contents of that store, instruction decode and memory access are outside the block.

Each virtual CPU context slot remembers whether it has been launched. The first entry into a slot must be a launch and every later entry must be a resume. Entry loads guest state only; host state is never saved on entry. An exit saves guest state and then reloads the single host handler context. It reports a reason code that stays until the next exit. The privilege ring is tracked apart from the mode: each slot keeps its own ring across exits, and the host handler always starts at ring 0. Commands that make no sense in the current state raise a one-cycle failure flag and change nothing.

Top module: `vmode_seq`

## Requirements
- R1: After reset, mode is 0 (off), exit_code is 0, priv_ring is 0, and fail and all three context requests are low.
- R2: The mode encoding is 0 = off, 1 = root, 2 = guest. From off, only a lone cmd_on leaves, and it goes to root. A lone cmd_off in root returns to off, clears every slot's launched flag and sets the ring to 0. Events and priv_set have no effect while off.
- R3: In root, a lone cmd_launch on an unlaunched slot, or a lone cmd_resume on a launched slot, pulses ctx_load_guest with ctx_slot set to that slot. Mode stays 1 until ctx_done is seen, and then becomes 2. The slot is then marked launched.
- R4: In root, a cmd_launch on a launched slot or a cmd_resume on an unlaunched slot raises fail and makes no transition.
- R5: In guest, an exit is caused by ev_irq (code 1), ev_pf (code 2), a lone cmd_hcall (code 3) or a lone cmd_off (code 4), with priority in that order. The code appears with the start of the exit and holds until the next exit.
- R6: An exit pulses ctx_save_guest and waits for ctx_done. It then pulses ctx_load_host and waits for ctx_done, and only then shows mode 1. Mode stays 2 throughout the exit.
- R7: In root or guest, priv_set loads priv_val into priv_ring. A first launch enters at ring 0. A resume enters at the ring the slot had when it last exited. Mode 1 after an exit shows ring 0.
- R8: The following raise fail for one cycle and have no command effect: cmd_on in root; cmd_hcall in root; cmd_on, cmd_launch or cmd_resume in guest; any command while a context request is outstanding; and two or more command strobes in one cycle.
- R9: The three context requests are one-cycle pulses, and at most one is high at a time.
- R10: ev_irq and ev_pf have no effect in root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | Enable-virtualization command strobe |
| cmd_off | input | 1 | Disable-virtualization command strobe |
| cmd_launch | input | 1 | First-launch command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_hcall | input | 1 | Guest hypercall command strobe |
| cmd_slot | input | SW | Context slot addressed by launch or resume |
| ev_irq | input | 1 | External interrupt event |
| ev_pf | input | 1 | Page fault event |
| priv_set | input | 1 | Ring write strobe |
| priv_val | input | 2 | Ring value to write |
| ctx_done | input | 1 | Context store completion strobe |
| mode | output | 2 | 0 off, 1 root, 2 guest |
| priv_ring | output | 2 | Current privilege ring |
| exit_code | output | 4 | Reason for the latest exit |
| fail | output | 1 | One-cycle invalid-command flag |
| ctx_save_guest | output | 1 | Request to save guest state |
| ctx_load_host | output | 1 | Request to load host handler state |
| ctx_load_guest | output | 1 | Request to load guest state |
| ctx_slot | output | SW | Slot of the current context |

## Verification
The bench builds the block with NSLOT = 2. With only two slots, random launch and resume commands keep hitting both already-launched and fresh slots, so the legal entry paths and both failure paths occur many times. The saved rings of the two slots are also restored and overwritten repeatedly. Random delays before ctx_done expose the mode hold during both handshakes. Directed steps add stacked events for priority, a command injected mid-handshake, and a disable followed by a relaunch.

// File: rtl/vmode_seq.sv
module vmode_seq #(
  parameter int NSLOT = 4,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_on,
  input  logic          cmd_off,
  input  logic          cmd_launch,
  input  logic          cmd_resume,
  input  logic          cmd_hcall,
  input  logic [SW-1:0] cmd_slot,
  input  logic          ev_irq,
  input  logic          ev_pf,
  input  logic          priv_set,
  input  logic [1:0]    priv_val,
  input  logic          ctx_done,
  output logic [1:0]    mode,
  output logic [1:0]    priv_ring,
  output logic [3:0]    exit_code,
  output logic          fail,
  output logic          ctx_save_guest,
  output logic          ctx_load_host,
  output logic          ctx_load_guest,
  output logic [SW-1:0] ctx_slot
);

  typedef enum logic [2:0] {ST_OFF, ST_ROOT, ST_GUEST, ST_ENTER, ST_SAVE, ST_RESTORE} st_t;

  st_t              st;
  logic [NSLOT-1:0] launched;
  logic [1:0]       gring [NSLOT];
  logic [1:0]       ring;
  logic [SW-1:0]    cur;
  logic [3:0]       code;
  logic             fail_q, save_q, lhost_q, lguest_q;
  logic             go_entry, go_exit, bad;
  logic [3:0]       why;

  wire any_cmd  = cmd_on | cmd_off | cmd_launch | cmd_resume | cmd_hcall;
  wire multi    = $countones({cmd_on, cmd_off, cmd_launch, cmd_resume, cmd_hcall}) > 1;
  wire one      = any_cmd & ~multi;
  wire slot_set = launched[cmd_slot];

  always_comb begin
    go_entry = 1'b0;
    go_exit  = 1'b0;
    bad      = 1'b0;
    why      = 4'd0;
    case (st)
      ST_OFF:  bad = any_cmd & ~(one & cmd_on);
      ST_ROOT: begin
        go_entry = one & ((cmd_launch & ~slot_set) | (cmd_resume & slot_set));
        bad      = any_cmd & ~go_entry & ~(one & cmd_off);
      end
      ST_GUEST: begin
        if (ev_irq)                why = 4'd1;
        else if (ev_pf)            why = 4'd2;
        else if (one & cmd_hcall)  why = 4'd3;
        else if (one & cmd_off)    why = 4'd4;
        go_exit = why != 4'd0;
        bad     = any_cmd & (multi | cmd_on | cmd_launch | cmd_resume);
      end
      default: bad = any_cmd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      launched <= '0;
      for (int i = 0; i < NSLOT; i++) gring[i] <= 2'd0;
      ring     <= 2'd0;
      cur      <= '0;
      code     <= 4'd0;
      fail_q   <= 1'b0;
      save_q   <= 1'b0;
      lhost_q  <= 1'b0;
      lguest_q <= 1'b0;
    end else begin
      fail_q   <= bad;
      save_q   <= 1'b0;
      lhost_q  <= 1'b0;
      lguest_q <= 1'b0;
      case (st)
        ST_OFF: if (one & cmd_on) st <= ST_ROOT;
        ST_ROOT: begin
          if (go_entry) begin
            st       <= ST_ENTER;
            cur      <= cmd_slot;
            lguest_q <= 1'b1;
          end else if (one & cmd_off) begin
            st       <= ST_OFF;
            launched <= '0;
            ring     <= 2'd0;
          end else if (priv_set) begin
            ring <= priv_val;
          end
        end
        ST_GUEST: begin
          if (go_exit) begin
            st         <= ST_SAVE;
            code       <= why;
            save_q     <= 1'b1;
            gring[cur] <= ring;
          end else if (priv_set) begin
            ring <= priv_val;
          end
        end
        ST_ENTER: if (ctx_done) begin
          st            <= ST_GUEST;
          ring          <= launched[cur] ? gring[cur] : 2'd0;
          launched[cur] <= 1'b1;
        end
        ST_SAVE: if (ctx_done) begin
          st      <= ST_RESTORE;
          lhost_q <= 1'b1;
        end
        ST_RESTORE: if (ctx_done) begin
          st   <= ST_ROOT;
          ring <= 2'd0;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign mode = (st == ST_OFF) ? 2'd0 :
                (st == ST_ROOT || st == ST_ENTER) ? 2'd1 : 2'd2;
  assign priv_ring      = ring;
  assign exit_code      = code;
  assign fail           = fail_q;
  assign ctx_save_guest = save_q;
  assign ctx_load_host  = lhost_q;
  assign ctx_load_guest = lguest_q;
  assign ctx_slot       = cur;

endmodule

// File: rtl/vmode_seq_chk.sv
module vmode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [3:0] exit_code,
  input logic       fail,
  input logic       ctx_save_guest,
  input logic       ctx_load_host,
  input logic       ctx_load_guest,
  input logic       ctx_done
);

  // R9
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctx_save_guest, ctx_load_host, ctx_load_guest}));

  // R9
  save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_save_guest |=> !ctx_save_guest);

  // R2
  off_no_guest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode != 2'd2));

  // R3
  entry_from_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load_guest |-> (mode == 2'd1));

  // R6
  exit_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && mode == 2'd1) |-> $past(ctx_done));

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_save_guest |-> $stable(exit_code));

  // R4
  fail_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !ctx_load_guest);

endmodule

bind vmode_seq vmode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .exit_code(exit_code), .fail(fail),
  .ctx_save_guest(ctx_save_guest), .ctx_load_host(ctx_load_host),
  .ctx_load_guest(ctx_load_guest), .ctx_done(ctx_done)
);

// File: tb/vmode_seq_test.sv
module vmode_seq_test;
  localparam int NSLOT = 2;
  localparam int SW = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_on = 0, cmd_off = 0, cmd_launch = 0, cmd_resume = 0, cmd_hcall = 0;
  logic [SW-1:0] cmd_slot = '0;
  logic ev_irq = 0, ev_pf = 0, priv_set = 0, ctx_done = 0;
  logic [1:0] priv_val = '0;
  logic [1:0] mode, priv_ring;
  logic [3:0] exit_code;
  logic fail, ctx_save_guest, ctx_load_host, ctx_load_guest;
  logic [SW-1:0] ctx_slot;

  vmode_seq #(.NSLOT(NSLOT)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_launch(cmd_launch), .cmd_resume(cmd_resume), .cmd_hcall(cmd_hcall),
    .cmd_slot(cmd_slot), .ev_irq(ev_irq), .ev_pf(ev_pf), .priv_set(priv_set),
    .priv_val(priv_val), .ctx_done(ctx_done), .mode(mode), .priv_ring(priv_ring),
    .exit_code(exit_code), .fail(fail), .ctx_save_guest(ctx_save_guest),
    .ctx_load_host(ctx_load_host), .ctx_load_guest(ctx_load_guest), .ctx_slot(ctx_slot)
  );

  int checks = 0, errs = 0, cyc = 0;
  bit over = 0;

  int mm = 0, mring = 0, mcode = 0, mcur = 0;
  bit ml [NSLOT];
  int mgr [NSLOT];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(int op);
    case (op)
      5, 9: return 1;
      6, 10: return 2;
      4: return 3;
      1: return 4;
      default: return 0;
    endcase
  endfunction

  // ops: 0 on,1 off,2 launch,3 resume,4 hcall,5 irq,6 pf,7 ring,8 launch+resume,
  //      9 irq+pf+hcall, 10 pf+hcall
  task automatic drive(int op, int slot, int v, bit val);
    cmd_on     = val && op == 0;
    cmd_off    = val && op == 1;
    cmd_launch = val && (op == 2 || op == 8);
    cmd_resume = val && (op == 3 || op == 8);
    cmd_hcall  = val && (op == 4 || op == 9 || op == 10);
    ev_irq     = val && (op == 5 || op == 9);
    ev_pf      = val && (op == 6 || op == 9 || op == 10);
    priv_set   = val && op == 7;
    priv_val   = 2'(v);
    cmd_slot   = SW'(slot);
  endtask

  task automatic wait_done(int d, int expmode, bit inject, string req);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk({req, " mode held"}, mode, expmode);
      chk("R9 request is one cycle", ctx_load_guest | ctx_save_guest | ctx_load_host, 0);
    end
    if (inject) begin
      @(negedge clk);
      cmd_on = 1;
      @(negedge clk);
      cmd_on = 0;
      chk("R8 command during handshake fails", fail, 1);
      chk("R8 command during handshake no effect", mode, expmode);
    end
    @(negedge clk);
    ctx_done = 1;
    @(negedge clk);
    ctx_done = 0;
  endtask

  task automatic do_op(int op, int slot, int v, bit inject);
    bit efail = 0;
    int kind = 0;  // 0 none,1 entry,2 exit,3 off,4 on,5 ring
    int eentry_ring = 0;
    case (mm)
      0: begin
        if (op == 0) kind = 4;
        else if (op inside {1, 2, 3, 4, 8, 9, 10}) efail = 1;
      end
      1: begin
        if (op inside {0, 4, 8, 9, 10}) efail = 1;
        else if (op == 1) kind = 3;
        else if (op == 2) begin if (ml[slot]) efail = 1; else begin kind = 1; eentry_ring = 0; end end
        else if (op == 3) begin if (!ml[slot]) efail = 1; else begin kind = 1; eentry_ring = mgr[slot]; end end
        else if (op == 7) kind = 5;
      end
      default: begin
        if (op inside {0, 2, 3, 8}) efail = 1;
        else if (op inside {1, 4, 5, 6, 9, 10}) kind = 2;
        else if (op == 7) kind = 5;
      end
    endcase
    @(negedge clk);
    drive(op, slot, v, 1);
    @(negedge clk);
    drive(op, slot, v, 0);
    chk("R8 R4 fail flag", fail, efail);
    case (kind)
      1: begin
        chk("R3 load guest pulse", ctx_load_guest, 1);
        chk("R3 mode root during entry", mode, 1);
        chk("R3 entry slot", ctx_slot, slot);
        wait_done($urandom_range(0, 3), 1, inject, "R3");
        chk("R3 guest after done", mode, 2);
        chk("R7 entry ring", priv_ring, eentry_ring);
        ml[slot] = 1; mcur = slot; mm = 2; mring = eentry_ring;
      end
      2: begin
        chk("R6 save pulse", ctx_save_guest, 1);
        chk("R5 exit code", exit_code, exp_code(op));
        chk("R6 mode guest during save", mode, 2);
        mgr[mcur] = mring;
        wait_done($urandom_range(0, 3), 2, 0, "R6 save");
        chk("R6 load host after save done", ctx_load_host, 1);
        chk("R6 mode guest during restore", mode, 2);
        wait_done($urandom_range(0, 3), 2, 0, "R6 restore");
        chk("R6 root after restore done", mode, 1);
        chk("R7 host ring zero", priv_ring, 0);
        mm = 1; mring = 0; mcode = exp_code(op);
      end
      3: begin
        mm = 0; mring = 0;
        for (int i = 0; i < NSLOT; i++) ml[i] = 0;
      end
      4: mm = 1;
      5: mring = v;
      default: ;
    endcase
    chk("R2 R10 mode", mode, mm);
    chk("R5 code held", exit_code, mcode);
    chk("R7 ring", priv_ring, mring);
    chk("R9 no stray request", ctx_load_guest | ctx_save_guest | ctx_load_host, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !over) begin
      over = 1;
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NSLOT; i++) begin ml[i] = 0; mgr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset code", exit_code, 0);
    chk("R1 reset ring", priv_ring, 0);
    chk("R1 reset fail", fail, 0);
    chk("R1 reset requests", ctx_load_guest | ctx_save_guest | ctx_load_host, 0);

    do_op(4, 0, 0, 0);   // R2 hcall while off fails
    do_op(5, 0, 0, 0);   // R2 irq while off ignored
    do_op(7, 0, 3, 0);   // R2 ring while off ignored
    do_op(0, 0, 0, 0);   // R2 enable
    do_op(0, 0, 0, 0);   // R8 enable in root
    do_op(3, 0, 0, 0);   // R4 resume unlaunched
    do_op(5, 0, 0, 0);   // R10 irq in root
    do_op(6, 0, 0, 0);   // R10 pf in root
    do_op(2, 0, 0, 0);   // R3 launch slot 0
    do_op(7, 0, 3, 0);   // R7 guest ring 3
    do_op(2, 1, 0, 0);   // R8 launch in guest
    do_op(5, 0, 0, 0);   // R5 irq exit
    do_op(7, 0, 2, 0);   // R7 host ring 2
    do_op(2, 0, 0, 0);   // R4 relaunch fails
    do_op(8, 0, 0, 0);   // R8 two commands
    do_op(3, 0, 0, 1);   // R3 resume with injected command, ring 3 back
    do_op(9, 0, 0, 0);   // R5 priority irq
    do_op(3, 0, 0, 0);
    do_op(10, 0, 0, 0);  // R5 priority pf
    do_op(3, 0, 0, 0);
    do_op(1, 0, 0, 0);   // R5 disable in guest, code 4
    do_op(2, 1, 0, 0);   // R3 launch slot 1
    do_op(4, 0, 0, 0);   // R5 hcall exit
    do_op(1, 0, 0, 0);   // R2 disable clears flags
    do_op(0, 0, 0, 0);
    do_op(3, 1, 0, 0);   // R2 resume fails after disable
    do_op(2, 1, 0, 0);   // R3 relaunch slot 1 enters at ring 0
    do_op(6, 0, 0, 0);

    for (int n = 0; n < 400; n++)
      do_op($urandom_range(0, 10), $urandom_range(0, NSLOT - 1), $urandom_range(0, 3), 0);

    if (!over) begin
      over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule